// File: doc/BRIEF.md
# Saturating Rounding Doubling Multiply-High Lane Unit

This block is a SIMD arithmetic datapath. It takes a packed vector operand A and picks one signed element out of a second vector operand B. Every active lane of A is multiplied by that element. Each product is doubled, rounded to nearest, and reduced to its upper half. The result is then clamped to the signed range of the lane. Lanes are 16 or 32 bits wide. The vector can be 64 or 128 bits wide, and a scalar mode processes a single lane.

The path from operands to result is purely combinational. A single sticky flag records whether any active lane has ever saturated. This flag is the only state in the block. It updates on a clock edge qualified by a valid strobe, and a synchronous clear input resets it. An encoding with a reserved size code produces an all-zero result, raises an undefined-encoding indication, and leaves the flag alone.

Top module: `sat_rdmulh_unit`

## Requirements
- R1: `size_code` 2'b01 selects 16-bit lanes and 2'b10 selects 32-bit lanes. Codes 2'b00 and 2'b11 drive `undef_enc` high and force `result` to all zeros.
- R2: With 16-bit lanes, the element of `op_b` used by every lane is number {idx_h,idx_l,idx_m} (0..7). Element k occupies bits [16k+15:16k].
- R3: With 32-bit lanes, the element of `op_b` is number {idx_h,idx_l} (0..3), at bits [32k+31:32k]. `idx_m` has no effect on the result.
- R4: Each active lane of width E outputs floor((2·a·b + 2^(E−1)) / 2^E), where a and b are signed. Lane e occupies bits [E·e+E−1:E·e] of `result`.
- R5: A lane saturates only when both a and b equal −2^(E−1). Its result is then 2^(E−1)−1.
- R6: In vector mode, `wide_q`=0 processes 64 bits, and `result[127:64]` is zero. `wide_q`=1 processes all 128 bits.
- R7: In scalar mode (`scalar_sel`=1), only lane 0 is computed and every bit above it is zero, whatever the value of `wide_q`.
- R8: `sat_sticky` is set on a rising clock edge when `valid` is high, the encoding is defined and an active lane saturates. Otherwise it holds its value.
- R9: `sat_clr` clears `sat_sticky` on the next rising edge, and it takes priority over a set in the same cycle.
- R10: `rst_n` low clears `sat_sticky` asynchronously.
- R11: Lanes outside the active width, and operations with an undefined encoding, never set `sat_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 128 | Packed lane operand |
| op_b | input | 128 | Vector holding the indexed element |
| size_code | input | 2 | Lane size code |
| wide_q | input | 1 | 0: 64-bit vector, 1: 128-bit vector |
| scalar_sel | input | 1 | Single-lane scalar mode |
| idx_h | input | 1 | Element index, top bit |
| idx_l | input | 1 | Element index, middle bit |
| idx_m | input | 1 | Element index, low bit (16-bit lanes only) |
| valid | input | 1 | Qualifies the operation for the flag update |
| sat_clr | input | 1 | Synchronous clear of the sticky flag |
| result | output | 128 | Packed lane results, zero above the active width |
| undef_enc | output | 1 | Reserved size code seen |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The bound checker checks the following on every cycle:
- zeroing of the upper half in 64-bit mode and above lane 0 in scalar mode;
- the clamp of lane 0 to the maximum when both factors are the most negative 16-bit value;
- the set, hold and clear behaviour of the sticky flag, including that undefined encodings never set it.

Only the bench's directed scenarios can show the following:
- the exact rounded value of every lane against an independent model;
- the dual role of the M index bit between lane sizes;
- the flag ignoring saturation in inactive lanes;
- the asynchronous reset taking effect between clock edges.

// File: rtl/srdm_pkg.sv
package srdm_pkg;
  localparam int VEC_W    = 128;
  localparam int HALF_W   = VEC_W / 2;
  localparam int NARROW_W = 16;
  localparam int WIDE_W   = 32;
  localparam int N_NARROW = VEC_W / NARROW_W;
  localparam int N_WIDE   = VEC_W / WIDE_W;

  typedef enum logic [1:0] {
    SZ_RSVD_LO = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_WORD    = 2'b10,
    SZ_RSVD_HI = 2'b11
  } size_e;
endpackage

// File: rtl/srdm_lane.sv
module srdm_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  output logic [EW-1:0] y,
  output logic          sat
);
  // Product width leaves headroom so the rounding add cannot wrap.
  localparam int PW = 2 * EW + 2;
  localparam logic signed [PW-1:0] HI = {{(PW-EW+1){1'b0}}, {(EW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(PW-EW+1){1'b1}}, {(EW-1){1'b0}}};
  localparam logic signed [PW-1:0] RND = HI + PW'(1);

  logic signed [PW-1:0] ax, bx, dbl, rnd, shf;

  always_comb begin
    ax  = PW'(signed'(a));
    bx  = PW'(signed'(b));
    dbl = (ax * bx) <<< 1;
    rnd = dbl + RND;
    shf = rnd >>> EW;
    sat = 1'b0;
    if (shf > HI) begin
      y   = HI[EW-1:0];
      sat = 1'b1;
    end else if (shf < LO) begin
      y   = LO[EW-1:0];
      sat = 1'b1;
    end else begin
      y = shf[EW-1:0];
    end
  end
endmodule

// File: rtl/srdm_bank.sv
module srdm_bank #(
  parameter int EW    = 16,
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]             a_vec,
  input  logic [VEC_W-1:0]             b_vec,
  input  logic [$clog2(VEC_W/EW)-1:0]  idx,
  input  logic [VEC_W/EW-1:0]          act,
  output logic [VEC_W-1:0]             y_vec,
  output logic                         sat_any
);
  localparam int N = VEC_W / EW;

  logic [EW-1:0] b_sel;
  logic [N-1:0]  lane_sat;

  assign b_sel = b_vec[int'(idx)*EW +: EW];

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [EW-1:0] y_raw;
    logic          s_raw;
    srdm_lane #(.EW(EW)) u_lane (
      .a   (a_vec[i*EW +: EW]),
      .b   (b_sel),
      .y   (y_raw),
      .sat (s_raw)
    );
    assign y_vec[i*EW +: EW] = act[i] ? y_raw : '0;
    assign lane_sat[i]       = act[i] & s_raw;
  end

  assign sat_any = |lane_sat;
endmodule

// File: rtl/srdm_decode.sv
module srdm_decode
  import srdm_pkg::*;
(
  input  logic [1:0]          size_code,
  input  logic                wide_q,
  input  logic                scalar_sel,
  input  logic                idx_h,
  input  logic                idx_l,
  input  logic                idx_m,
  output logic                undef,
  output logic                is_word,
  output logic [2:0]          idx_n,
  output logic [1:0]          idx_w,
  output logic [N_NARROW-1:0] act_n,
  output logic [N_WIDE-1:0]   act_w
);
  size_e sz;
  logic  en_n, en_w;

  assign sz      = size_e'(size_code);
  assign undef   = (sz == SZ_RSVD_LO) || (sz == SZ_RSVD_HI);
  assign is_word = (sz == SZ_WORD);
  assign en_n    = (sz == SZ_HALF);
  assign en_w    = is_word;
  assign idx_n   = {idx_h, idx_l, idx_m};
  assign idx_w   = {idx_h, idx_l};

  for (genvar i = 0; i < N_NARROW; i++) begin : g_act_n
    assign act_n[i] = en_n && (scalar_sel ? (i == 0) : (wide_q || (i < N_NARROW / 2)));
  end
  for (genvar i = 0; i < N_WIDE; i++) begin : g_act_w
    assign act_w[i] = en_w && (scalar_sel ? (i == 0) : (wide_q || (i < N_WIDE / 2)));
  end
endmodule

// File: rtl/sat_rdmulh_unit.sv
module sat_rdmulh_unit
  import srdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VEC_W-1:0]  op_a,
  input  logic [VEC_W-1:0]  op_b,
  input  logic [1:0]        size_code,
  input  logic              wide_q,
  input  logic              scalar_sel,
  input  logic              idx_h,
  input  logic              idx_l,
  input  logic              idx_m,
  input  logic              valid,
  input  logic              sat_clr,
  output logic [VEC_W-1:0]  result,
  output logic              undef_enc,
  output logic              sat_sticky
);
  logic                undef, is_word;
  logic [2:0]          idx_n;
  logic [1:0]          idx_w;
  logic [N_NARROW-1:0] act_n;
  logic [N_WIDE-1:0]   act_w;
  logic [VEC_W-1:0]    y_n, y_w;
  logic                sat_n, sat_w, sat_any;
  logic                sticky_d, sticky_q;

  srdm_decode u_dec (
    .size_code  (size_code),
    .wide_q     (wide_q),
    .scalar_sel (scalar_sel),
    .idx_h      (idx_h),
    .idx_l      (idx_l),
    .idx_m      (idx_m),
    .undef      (undef),
    .is_word    (is_word),
    .idx_n      (idx_n),
    .idx_w      (idx_w),
    .act_n      (act_n),
    .act_w      (act_w)
  );

  srdm_bank #(.EW(NARROW_W), .VEC_W(VEC_W)) u_bank_n (
    .a_vec   (op_a),
    .b_vec   (op_b),
    .idx     (idx_n),
    .act     (act_n),
    .y_vec   (y_n),
    .sat_any (sat_n)
  );

  srdm_bank #(.EW(WIDE_W), .VEC_W(VEC_W)) u_bank_w (
    .a_vec   (op_a),
    .b_vec   (op_b),
    .idx     (idx_w),
    .act     (act_w),
    .y_vec   (y_w),
    .sat_any (sat_w)
  );

  // Both banks zero inactive lanes, so an undefined code yields zero here.
  assign result    = is_word ? y_w : y_n;
  assign sat_any   = is_word ? sat_w : sat_n;
  assign undef_enc = undef;

  always_comb begin
    sticky_d = sticky_q;
    if (sat_clr) begin
      sticky_d = 1'b0;
    end else if (valid && !undef && sat_any) begin
      sticky_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
    end
  end

  assign sat_sticky = sticky_q;
endmodule

// File: rtl/srdm_checker.sv
module srdm_checker (
  input logic         clk,
  input logic         rst_n,
  input logic [127:0] op_a,
  input logic [127:0] op_b,
  input logic [1:0]   size_code,
  input logic         wide_q,
  input logic         scalar_sel,
  input logic         idx_h,
  input logic         idx_l,
  input logic         idx_m,
  input logic         valid,
  input logic         sat_clr,
  input logic [127:0] result,
  input logic         undef_enc,
  input logic         sat_sticky
);
  logic [15:0] b16;
  logic        min_pair16;

  assign b16        = op_b[int'({idx_h, idx_l, idx_m})*16 +: 16];
  assign min_pair16 = (size_code == 2'b01) && (op_a[15:0] == 16'h8000) && (b16 == 16'h8000);

  p_undef_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    undef_enc |-> (result == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    min_pair16 |-> (result[15:0] == 16'h7fff));

  p_half_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scalar_sel && !wide_q) |-> (result[127:64] == '0));

  p_scalar_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scalar_sel && size_code == 2'b01) |-> (result[127:16] == '0));

  p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (min_pair16 && valid && !sat_clr) |=> sat_sticky);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr |=> !sat_sticky);

  p_undef_noflag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_enc && !sat_sticky) |=> !sat_sticky);
endmodule

bind sat_rdmulh_unit srdm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_a       (op_a),
  .op_b       (op_b),
  .size_code  (size_code),
  .wide_q     (wide_q),
  .scalar_sel (scalar_sel),
  .idx_h      (idx_h),
  .idx_l      (idx_l),
  .idx_m      (idx_m),
  .valid      (valid),
  .sat_clr    (sat_clr),
  .result     (result),
  .undef_enc  (undef_enc),
  .sat_sticky (sat_sticky)
);

// File: tb/tb_sat_rdmulh_unit.sv
module tb_sat_rdmulh_unit;
  localparam time CLK_P = 20ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] op_a, op_b;
  logic [1:0]   size_code;
  logic         wide_q, scalar_sel, idx_h, idx_l, idx_m, valid, sat_clr;
  logic [127:0] result;
  logic         undef_enc, sat_sticky;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic exp_sticky = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sat_rdmulh_unit dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .size_code(size_code),
    .wide_q(wide_q), .scalar_sel(scalar_sel), .idx_h(idx_h), .idx_l(idx_l),
    .idx_m(idx_m), .valid(valid), .sat_clr(sat_clr), .result(result),
    .undef_enc(undef_enc), .sat_sticky(sat_sticky)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent model of the requirements.
  function automatic void model(input logic [127:0] a, input logic [127:0] b,
                                input logic [1:0] sz, input logic q, input logic sc,
                                input logic h, input logic l, input logic m,
                                output logic [127:0] y, output logic s, output logic ud);
    int es, idx, n;
    logic signed [67:0] av, bv, p, hi, lo;
    y = '0; s = 1'b0;
    ud = (sz == 2'b00) || (sz == 2'b11);
    if (ud) return;
    es  = (sz == 2'b01) ? 16 : 32;
    idx = (es == 16) ? int'({h, l, m}) : int'({h, l});
    n   = sc ? 1 : ((q ? 128 : 64) / es);
    bv  = (es == 16) ? 68'(signed'(b[idx*16 +: 16])) : 68'(signed'(b[idx*32 +: 32]));
    hi  = (68'sd1 <<< (es - 1)) - 68'sd1;
    lo  = -(68'sd1 <<< (es - 1));
    for (int e = 0; e < n; e++) begin
      av = (es == 16) ? 68'(signed'(a[e*16 +: 16])) : 68'(signed'(a[e*32 +: 32]));
      p  = (68'sd2 * av * bv + (68'sd1 <<< (es - 1))) >>> es;
      if (p > hi) begin p = hi; s = 1'b1; end
      else if (p < lo) begin p = lo; s = 1'b1; end
      if (es == 16) y[e*16 +: 16] = p[15:0];
      else          y[e*32 +: 32] = p[31:0];
    end
  endfunction

  // Apply one operation, check result at once and the flag after one edge.
  task automatic run_op(string req, logic [1:0] sz, logic q, logic sc, logic [2:0] hlm,
                        logic [127:0] a, logic [127:0] b, logic clr = 1'b0);
    logic [127:0] ey; logic es, eu;
    @(negedge clk);
    op_a = a; op_b = b; size_code = sz; wide_q = q; scalar_sel = sc;
    {idx_h, idx_l, idx_m} = hlm; valid = 1'b1; sat_clr = clr;
    model(a, b, sz, q, sc, hlm[2], hlm[1], hlm[0], ey, es, eu);
    #2;
    check(req, result, ey);
    check(req, 128'(undef_enc), 128'(eu));
    @(negedge clk);
    valid = 1'b0; sat_clr = 1'b0;
    if (clr) exp_sticky = 1'b0;
    else if (es && !eu) exp_sticky = 1'b1;
    #1;
    check(req, 128'(sat_sticky), 128'(exp_sticky));
  endtask

  task automatic clear_flag();
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0; exp_sticky = 1'b0;
    #1; check("R9", 128'(sat_sticky), 128'(0));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic t_reset();
    #1; check("R10", 128'(sat_sticky), 128'(0));
  endtask

  task automatic t_narrow();
    for (int k = 0; k < 8; k++) run_op("R2", 2'b01, 1'b1, 1'b0, 3'(k), rnd128(), rnd128());
    for (int k = 0; k < 4; k++) run_op("R6", 2'b01, 1'b0, 1'b0, 3'(k), rnd128(), rnd128());
    clear_flag();
  endtask

  task automatic t_word();
    logic [127:0] a, b, r0;
    for (int k = 0; k < 4; k++) begin
      a = rnd128(); b = rnd128();
      run_op("R3", 2'b10, 1'b1, 1'b0, {2'(k), 1'b0}, a, b);
      r0 = result;
      run_op("R3", 2'b10, 1'b1, 1'b0, {2'(k), 1'b1}, a, b);
      check("R3", result, r0);
    end
    run_op("R6", 2'b10, 1'b0, 1'b0, 3'b010, rnd128(), rnd128());
    clear_flag();
  endtask

  task automatic t_round();
    run_op("R4", 2'b01, 1'b0, 1'b0, 3'b000, {48'd0, 16'hffff, 16'h7fff, 16'h0001, 16'h0001},
           {112'd0, 16'h4000});
    check("R4", result, {64'd0, 16'h0000, 16'h4000, 16'h0001, 16'h0001});
    run_op("R4", 2'b01, 1'b0, 1'b0, 3'b000, {48'd0, 16'h0001}, {112'd0, 16'h3fff});
    check("R4", result, 128'd0);
    run_op("R4", 2'b10, 1'b1, 1'b0, 3'b000, {96'd0, 32'h0000_0003}, {96'd0, 32'h4000_0000});
    check("R4", result, 128'd2);
  endtask

  task automatic t_sat();
    run_op("R5", 2'b01, 1'b0, 1'b0, 3'b000, {48'd0, 16'h8000}, {112'd0, 16'h8001});
    check("R5", 128'(sat_sticky), 128'(0));
    run_op("R5", 2'b01, 1'b1, 1'b0, 3'b101, {8{16'h8000}}, {16'h0, 16'h0, 16'h8000, 80'h0});
    check("R5", result, {8{16'h7fff}});
    check("R8", 128'(sat_sticky), 128'(1));
    run_op("R8", 2'b01, 1'b1, 1'b0, 3'b000, rnd128(), 128'd5);
    check("R8", 128'(sat_sticky), 128'(1));
    run_op("R9", 2'b10, 1'b1, 1'b0, 3'b000, {4{32'h8000_0000}}, {96'd0, 32'h8000_0000}, 1'b1);
    check("R9", 128'(sat_sticky), 128'(0));
    run_op("R5", 2'b10, 1'b1, 1'b0, 3'b000, {4{32'h8000_0000}}, {96'd0, 32'h8000_0000});
    check("R5", result, {4{32'h7fff_ffff}});
    clear_flag();
  endtask

  task automatic t_scalar();
    run_op("R7", 2'b01, 1'b1, 1'b1, 3'b011, rnd128(), rnd128());
    run_op("R7", 2'b10, 1'b1, 1'b1, 3'b011, rnd128(), rnd128());
    clear_flag();
  endtask

  task automatic t_inactive();
    run_op("R11", 2'b01, 1'b0, 1'b0, 3'b000, {{4{16'h8000}}, 64'd1}, {112'd0, 16'h8000});
    check("R11", 128'(sat_sticky), 128'(0));
    run_op("R11", 2'b01, 1'b1, 1'b1, 3'b000, {{7{16'h8000}}, 16'd3}, {112'd0, 16'h8000});
    check("R11", 128'(sat_sticky), 128'(0));
    run_op("R1", 2'b00, 1'b1, 1'b0, 3'b000, {8{16'h8000}}, {8{16'h8000}});
    check("R1", result, 128'd0);
    check("R11", 128'(sat_sticky), 128'(0));
    run_op("R1", 2'b11, 1'b1, 1'b0, 3'b000, rnd128(), rnd128());
    check("R1", 128'(undef_enc), 128'(1));
  endtask

  task automatic t_async_reset();
    run_op("R10", 2'b01, 1'b0, 1'b1, 3'b000, {112'd0, 16'h8000}, {112'd0, 16'h8000});
    #3 rst_n = 1'b0;
    #1 check("R10", 128'(sat_sticky), 128'(0));
    exp_sticky = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_a = '0; op_b = '0; size_code = 2'b01; wide_q = 1'b0;
    scalar_sel = 1'b0; idx_h = 1'b0; idx_l = 1'b0; idx_m = 1'b0; valid = 1'b0; sat_clr = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_narrow();
    t_word();
    t_round();
    t_sat();
    t_scalar();
    t_inactive();
    t_async_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule